// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block generates the status flags and the interrupt line for the transmit and receive FIFOs of a serial peripheral controller. It watches the two FIFO fill levels and the push and pop strobes with their full and empty flags. From these it derives two level-based conditions and three error events. The level conditions are "transmit running low" and "receive has data waiting". The errors are a push into a full transmit FIFO, a push into a full receive FIFO, and a pop from an empty receive FIFO. The two level conditions are compared against programmable thresholds. The three errors latch until software clears them or the controller is disabled.

Software programs the two thresholds and a five-bit enable mask through write strobes. A threshold write is kept only when the value is below the FIFO depth. Any other value leaves the old contents in place, so software can find the depth by writing large values and reading them back. The block presents a raw status vector, a masked status vector and one combined interrupt line. It also gives registered copies of both fill levels. Every output is registered and reflects the inputs sampled at the previous clock edge.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While reset is high, every output is zero: the status vectors, the interrupt line, the thresholds, the mask and the level counts.
- R2: Status bit 0 (transmit low) is set one cycle after a cycle in which the transmit level is at or below the effective transmit threshold.
- R3: Status bit 4 (receive waiting) is set one cycle after a cycle in which the receive level is strictly greater than the effective receive threshold. A threshold of N-1 therefore fires once N entries are present.
- R4: Status bit 1 (transmit overflow) is set one cycle after a cycle in which the transmit push strobe and the transmit full flag are both high, and it stays set.
- R5: Status bit 3 (receive overflow) latches on a receive push while the receive FIFO is full. Status bit 2 (receive underflow) latches on a receive pop while the receive FIFO is empty.
- R6: The clear strobe zeroes the three error bits one cycle later. An event in the same cycle as the clear still sets its bit. While the enable input is low, the error bits are held at zero and events are ignored.
- R7: A threshold write takes effect only when the written value is below DEPTH. Otherwise the stored threshold is unchanged. The effective threshold in a cycle is the value just written when that write is accepted, and the stored value otherwise.
- R8: The masked status equals the raw status ANDed with the mask. A mask bit of 1 enables its source. A mask write takes effect in the same update as the status it masks. The mask is zero after reset.
- R9: The interrupt line is the OR of the masked status bits. With a mask of all zeros it stays low.
- R10: The two level-count outputs repeat the transmit and receive level inputs one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; low holds the error flags at zero |
| tx_level | input | LVL_W | Current transmit FIFO fill level |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| tx_push | input | 1 | Transmit FIFO push strobe |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_push | input | 1 | Receive FIFO push strobe |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_pop | input | 1 | Receive FIFO pop strobe |
| rx_empty | input | 1 | Receive FIFO empty flag |
| tx_thr_wr | input | 1 | Write strobe for the transmit threshold |
| rx_thr_wr | input | 1 | Write strobe for the receive threshold |
| mask_wr | input | 1 | Write strobe for the mask |
| wdata | input | WD_W | Write data for thresholds; low NSRC bits for the mask |
| err_clr | input | 1 | Clear strobe for the sticky error flags |
| tx_thr | output | THR_W | Stored transmit threshold |
| rx_thr | output | THR_W | Stored receive threshold |
| irq_mask | output | NSRC | Stored mask |
| raw_stat | output | NSRC | Raw status |
| irq_stat | output | NSRC | Masked status |
| irq | output | 1 | Combined interrupt |
| tx_count | output | LVL_W | Registered transmit level |
| rx_count | output | LVL_W | Registered receive level |

## Verification
Every result appears exactly one clock after the stimulus that causes it. This holds for threshold and mask writes, level changes, error events and clears alike. The bench drives inputs on the falling edge and runs its reference model at the rising edge. It then compares all outputs on the next falling edge, so each check looks at the single update that the last stimulus caused. Directed cases cover threshold writes at DEPTH-1, at DEPTH and at the largest value. They also cover a write and a level change in the same cycle, a clear that coincides with an event, and a fully zero mask. Seeded random cycles then mix all the strobes together.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int NSRC    = 5;
  localparam int SRC_TXE = 0;
  localparam int SRC_TXO = 1;
  localparam int SRC_RXU = 2;
  localparam int SRC_RXO = 3;
  localparam int SRC_RXF = 4;
  localparam int NERR    = 3;
endpackage

// File: rtl/fic_thr_reg.sv
module fic_thr_reg #(
  parameter int DEPTH = 16,
  parameter int WD_W  = 8,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WD_W-1:0]  wdata,
  output logic [THR_W-1:0] q_next,
  output logic [THR_W-1:0] q
);
  logic accept;

  always_comb begin
    accept = wr && (32'(wdata) < DEPTH);
    q_next = accept ? wdata[THR_W-1:0] : q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

  // R7: an out-of-range write leaves the stored value alone
  assert_reject_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && 32'(wdata) >= DEPTH) |=> $stable(q));
  // R7: an in-range write lands
  assert_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && 32'(wdata) < DEPTH) |=> (32'(q) == 32'($past(wdata))));
endmodule

// File: rtl/fic_sticky.sv
module fic_sticky (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic clr,
  input  logic ev,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || !enable) flag <= 1'b0;
    else if (ev)        flag <= 1'b1;
    else if (clr)       flag <= 1'b0;
  end

  assert_event_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && ev) |=> flag);
  assert_disable_clears_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !flag);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (flag && enable && !clr) |=> flag);
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fic_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WD_W  = 8,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_push,
  input  logic             tx_full,
  input  logic             rx_push,
  input  logic             rx_full,
  input  logic             rx_pop,
  input  logic             rx_empty,
  input  logic             tx_thr_wr,
  input  logic             rx_thr_wr,
  input  logic             mask_wr,
  input  logic [WD_W-1:0]  wdata,
  input  logic             err_clr,
  output logic [THR_W-1:0] tx_thr,
  output logic [THR_W-1:0] rx_thr,
  output logic [NSRC-1:0]  irq_mask,
  output logic [NSRC-1:0]  raw_stat,
  output logic [NSRC-1:0]  irq_stat,
  output logic             irq,
  output logic [LVL_W-1:0] tx_count,
  output logic [LVL_W-1:0] rx_count
);
  localparam int ERR_IDX [NERR] = '{SRC_TXO, SRC_RXU, SRC_RXO};

  logic [THR_W-1:0] tx_thr_nx, rx_thr_nx;
  logic [NSRC-1:0]  mask_nx, raw_nx, masked_nx;
  logic [NERR-1:0]  err_ev, err_q;
  logic             txe_nx, rxf_nx;

  fic_thr_reg #(.DEPTH(DEPTH), .WD_W(WD_W), .THR_W(THR_W)) u_tx_thr (
    .clk(clk), .rst(rst), .wr(tx_thr_wr), .wdata(wdata),
    .q_next(tx_thr_nx), .q(tx_thr));

  fic_thr_reg #(.DEPTH(DEPTH), .WD_W(WD_W), .THR_W(THR_W)) u_rx_thr (
    .clk(clk), .rst(rst), .wr(rx_thr_wr), .wdata(wdata),
    .q_next(rx_thr_nx), .q(rx_thr));

  assign err_ev[0] = tx_push & tx_full;
  assign err_ev[1] = rx_pop  & rx_empty;
  assign err_ev[2] = rx_push & rx_full;

  for (genvar g = 0; g < NERR; g++) begin : g_err
    fic_sticky u_flag (
      .clk(clk), .rst(rst), .enable(enable), .clr(err_clr),
      .ev(err_ev[g]), .flag(err_q[g]));
  end

  always_comb begin
    mask_nx = mask_wr ? wdata[NSRC-1:0] : irq_mask;
    txe_nx  = 32'(tx_level) <= 32'(tx_thr_nx);
    rxf_nx  = 32'(rx_level) >  32'(rx_thr_nx);
  end

  always_comb begin
    raw_nx          = '0;
    raw_nx[SRC_TXE] = txe_nx;
    raw_nx[SRC_RXF] = rxf_nx;
    for (int i = 0; i < NERR; i++) begin
      if (!(rst || !enable)) begin
        if (err_ev[i])       raw_nx[ERR_IDX[i]] = 1'b1;
        else if (!err_clr)   raw_nx[ERR_IDX[i]] = err_q[i];
      end
    end
    masked_nx = raw_nx & mask_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_mask <= '0;
      raw_stat <= '0;
      irq_stat <= '0;
      irq      <= 1'b0;
      tx_count <= '0;
      rx_count <= '0;
    end else begin
      irq_mask <= mask_nx;
      raw_stat <= raw_nx;
      irq_stat <= masked_nx;
      irq      <= |masked_nx;
      tx_count <= tx_level;
      rx_count <= rx_level;
    end
  end

  // R8: masked view never shows a bit the raw view lacks
  assert_masked_subset_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_stat & ~raw_stat) == '0);
  // R8: masked view agrees with the stored mask
  assert_masked_by_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_stat & ~irq_mask) == '0);
  // R9: zero mask keeps the line quiet
  assert_zero_mask_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_mask == '0) |-> !irq);
  // R9: line follows masked status
  assert_line_or_R9: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_stat != '0));
  // R4: error flag in the status matches the sticky register
  assert_err_mirror_R4: assert property (@(posedge clk) disable iff (rst)
    raw_stat[SRC_TXO] == err_q[0]);
  // R10: counts follow levels
  assert_count_R10: assert property (@(posedge clk) disable iff (rst)
    tx_count == $past(tx_level));
endmodule

// File: tb/tb_fifo_irq_ctrl.sv
module tb_fifo_irq_ctrl;
  localparam int DEPTH = 16;
  localparam int WD_W  = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int THR_W = $clog2(DEPTH);
  localparam int NSRC  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic tx_push = 0, tx_full = 0, rx_push = 0, rx_full = 0, rx_pop = 0, rx_empty = 0;
  logic tx_thr_wr = 0, rx_thr_wr = 0, mask_wr = 0, err_clr = 0;
  logic [WD_W-1:0] wdata = '0;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [NSRC-1:0] irq_mask, raw_stat, irq_stat;
  logic irq;
  logic [LVL_W-1:0] tx_count, rx_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_txthr, m_rxthr, m_mask, m_txo, m_rxu, m_rxo, m_raw, m_msk, m_irq, m_txc, m_rxc;

  always #4 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(DEPTH), .WD_W(WD_W)) dut (
    .clk(clk), .rst(rst), .enable(enable), .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .tx_full(tx_full), .rx_push(rx_push), .rx_full(rx_full),
    .rx_pop(rx_pop), .rx_empty(rx_empty), .tx_thr_wr(tx_thr_wr), .rx_thr_wr(rx_thr_wr),
    .mask_wr(mask_wr), .wdata(wdata), .err_clr(err_clr), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .irq_mask(irq_mask), .raw_stat(raw_stat), .irq_stat(irq_stat), .irq(irq),
    .tx_count(tx_count), .rx_count(rx_count));

  function automatic int sticky(int f, int ev);
    if (!enable) return 0;
    if (ev != 0) return 1;
    if (err_clr) return 0;
    return f;
  endfunction

  task automatic model_reset();
    m_txthr = 0; m_rxthr = 0; m_mask = 0; m_txo = 0; m_rxu = 0; m_rxo = 0;
    m_raw = 0; m_msk = 0; m_irq = 0; m_txc = 0; m_rxc = 0;
  endtask

  // Reference update from the requirements, applied at a rising edge
  task automatic model_step();
    if (tx_thr_wr && int'(wdata) < DEPTH) m_txthr = int'(wdata);   // R7
    if (rx_thr_wr && int'(wdata) < DEPTH) m_rxthr = int'(wdata);   // R7
    if (mask_wr) m_mask = int'(wdata) & 5'h1f;                     // R8
    m_txo = sticky(m_txo, int'(tx_push & tx_full));                // R4
    m_rxu = sticky(m_rxu, int'(rx_pop & rx_empty));                // R5
    m_rxo = sticky(m_rxo, int'(rx_push & rx_full));                // R5
    m_raw = ((int'(tx_level) <= m_txthr) ? 1 : 0)                  // R2
          | (m_txo << 1) | (m_rxu << 2) | (m_rxo << 3)
          | ((int'(rx_level) > m_rxthr) ? 16 : 0);                 // R3
    m_msk = m_raw & m_mask;
    m_irq = (m_msk != 0) ? 1 : 0;                                  // R9
    m_txc = int'(tx_level); m_rxc = int'(rx_level);                // R10
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R7 tx threshold", int'(tx_thr), m_txthr);
    chk("R7 rx threshold", int'(rx_thr), m_rxthr);
    chk("R8 mask", int'(irq_mask), m_mask);
    chk("R2/R3/R4/R5/R6 raw status", int'(raw_stat), m_raw);
    chk("R8 masked status", int'(irq_stat), m_msk);
    chk("R9 interrupt", int'(irq), m_irq);
    chk("R10 tx count", int'(tx_count), m_txc);
    chk("R10 rx count", int'(rx_count), m_rxc);
  endtask

  task automatic idle();
    tx_push = 0; tx_full = 0; rx_push = 0; rx_full = 0; rx_pop = 0; rx_empty = 0;
    tx_thr_wr = 0; rx_thr_wr = 0; mask_wr = 0; err_clr = 0;
  endtask

  // inputs are already set; run one edge and compare at the next falling edge
  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    idle();
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 raw", int'(raw_stat), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 mask/thr", int'(irq_mask) | int'(tx_thr) | int'(rx_thr), 0);
    chk("R1 counts", int'(tx_count) | int'(rx_count), 0);
    rst = 0; enable = 1;
    tx_level = 5'd4; rx_level = 5'd0;
    cycle();

    // R7: DEPTH-1 accepted, DEPTH and max rejected
    wdata = 8'(DEPTH - 1); tx_thr_wr = 1; cycle();
    chk("R7 accept top", int'(tx_thr), DEPTH - 1);
    wdata = 8'(DEPTH); tx_thr_wr = 1; cycle();
    chk("R7 reject depth", int'(tx_thr), DEPTH - 1);
    wdata = 8'hff; tx_thr_wr = 1; rx_thr_wr = 1; cycle();
    chk("R7 reject max", int'(rx_thr), 0);

    // R3: threshold 3, level 3 quiet, level 4 fires; write and level in same cycle
    wdata = 8'd3; rx_thr_wr = 1; rx_level = 5'd3; cycle();
    chk("R3 at threshold", int'(raw_stat[4]), 0);
    rx_level = 5'd4; cycle();
    chk("R3 above threshold", int'(raw_stat[4]), 1);

    // R2: transmit low boundary
    wdata = 8'd2; tx_thr_wr = 1; tx_level = 5'd3; cycle();
    chk("R2 above", int'(raw_stat[0]), 0);
    tx_level = 5'd2; cycle();
    chk("R2 equal", int'(raw_stat[0]), 1);

    // R4/R5/R6: events, sticky, clear racing an event
    tx_push = 1; tx_full = 1; cycle();
    chk("R4 set", int'(raw_stat[1]), 1);
    cycle();
    chk("R4 held", int'(raw_stat[1]), 1);
    rx_pop = 1; rx_empty = 1; rx_push = 1; rx_full = 1; cycle();
    chk("R5 both", int'(raw_stat[3:2]), 3);
    err_clr = 1; rx_pop = 1; rx_empty = 1; cycle();
    chk("R6 clear with event", int'(raw_stat[3:1]), 3'b010);
    enable = 0; tx_push = 1; tx_full = 1; cycle();
    chk("R6 disabled", int'(raw_stat[3:1]), 0);
    enable = 1;

    // R8/R9: mask zero silences, all-ones passes
    tx_push = 1; tx_full = 1; wdata = 8'h00; mask_wr = 1; cycle();
    chk("R9 zero mask", int'(irq), 0);
    wdata = 8'h1f; mask_wr = 1; cycle();
    chk("R8 full mask", int'(irq_stat), int'(raw_stat));
    chk("R9 line", int'(irq), 1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      tx_level = LVL_W'($urandom_range(0, DEPTH));
      rx_level = LVL_W'($urandom_range(0, DEPTH));
      tx_push = ($urandom_range(0, 9) == 0); tx_full = $urandom_range(0, 1);
      rx_push = ($urandom_range(0, 9) == 0); rx_full = $urandom_range(0, 1);
      rx_pop  = ($urandom_range(0, 9) == 0); rx_empty = $urandom_range(0, 1);
      err_clr = ($urandom_range(0, 7) == 0);
      tx_thr_wr = ($urandom_range(0, 7) == 0);
      rx_thr_wr = ($urandom_range(0, 7) == 0);
      mask_wr = ($urandom_range(0, 7) == 0);
      wdata = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(DEPTH, 255))
                                          : 8'($urandom_range(0, DEPTH - 1));
      enable = ($urandom_range(0, 19) != 0);
      cycle();
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule